// File: doc/BRIEF.md
# TLB Invalidation Sequencer

This block holds the tag side of a translation buffer: a set-associative part of `SA_WAYS` ways by `SA_ROWS` rows and a fully-associative part of `FA_ENTRIES` entries. Each entry stores a global flag, an address-space identifier, a page-size exponent, a virtual page-pair number and an exist bit. A fill port loads entries. A command port takes invalidation requests that clear the exist bit of every entry meeting a chosen criterion.

A command starts a walk over all entries. The walk takes one entry per clock. For each entry the block evaluates the match predicate against the latched command operands and, on a hit, writes exist = 0. Two command families are supported. The first is selected by a 3-bit opcode and matches on the global flag, the address-space identifier, or the virtual address at the entry's own page size. The second clears one set-associative row across every way, or the whole fully-associative region, either unconditionally or only for non-global entries of one address space. Unknown requests raise a one-cycle illegal flag and change nothing.

Top module: `tlbinv_seq`

## Requirements
- R1: While reset is low and after it is released, every exist bit is 0 and `busy_o`, `done_o` and `illegal_o` are 0.
- R2: When `fill_en` is high and `busy_o` is low, the entry at `fill_index` takes the fill fields and its exist bit becomes 1 from the next cycle. A fill offered while `busy_o` is high is ignored. Only a fill sets an exist bit.
- R3: A command is accepted when `cmd_valid` is high and `busy_o` is low. A legal command raises `busy_o` for exactly N = SA_WAYS*SA_ROWS+FA_ENTRIES cycles, starting the cycle after acceptance. `done_o` is high for one cycle, the first cycle in which `busy_o` is low again. Commands offered while busy are ignored.
- R4: With `cmd_kind` = 0 (by opcode), opcodes 0 and 1 clear every entry, opcode 2 clears only entries whose global flag is 1, and opcode 3 clears only entries whose global flag is 0.
- R5: Opcode 4 clears entries that are non-global and whose identifier equals `cmd_asid`.
- R6: Opcode 5 clears non-global entries whose identifier matches and whose address matches. Opcode 6 clears entries that are global or have a matching identifier, provided the address matches.
- R7: An entry's address matches when `cmd_vaddr >> (ps+1)` equals `{vppn, 13'b0} >> (ps+1)`, where ps is that entry's own stored page-size exponent.
- R8: Opcode 7 with `cmd_kind` = 0, or any command with `cmd_kind` = 3, raises `illegal_o` for one cycle right after acceptance. Such a command starts no walk and clears nothing.
- R9: Entry index `way*SA_ROWS + row` is set-associative for indices below SA_WAYS*SA_ROWS. With `cmd_kind` = 1, an index below that bound clears row `cmd_index mod SA_ROWS` in every way.
- R10: With `cmd_kind` = 1, an index within the fully-associative range clears every fully-associative entry. An index at or beyond N clears nothing, but the walk and `done_o` still occur.
- R11: `cmd_kind` = 2 selects the same entries as `cmd_kind` = 1, but clears only the selected entries that are non-global and whose identifier equals `cmd_asid`.
- R12: During a walk, at most one exist bit changes per cycle, in ascending entry order. The entry checked k cycles after acceptance is index k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | 0 by opcode, 1 row/region clear all, 2 row/region clear by identifier, 3 reserved |
| cmd_op | input | 3 | Opcode for kind 0 |
| cmd_asid | input | 10 | Identifier operand |
| cmd_vaddr | input | VA_W | Virtual address operand |
| cmd_index | input | IDX_W | Index operand for kinds 1 and 2 |
| fill_en | input | 1 | Fill request |
| fill_index | input | PTR_W | Entry to fill |
| fill_global | input | 1 | Global flag to store |
| fill_asid | input | 10 | Identifier to store |
| fill_ps | input | 6 | Page-size exponent to store |
| fill_vppn | input | VA_W-13 | Virtual page-pair number to store |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| illegal_o | output | 1 | One-cycle pulse for a rejected command |
| exist_o | output | N | Exist bit of every entry |

## Verification
The hardest case is the address-qualified clear. An entry hits there only when its own page-size exponent, its identifier and its global flag all line up with the operands. The fill pattern therefore gives entries a page number equal to the target address with a few low bits flipped, and rotates the exponent through five values. The same address then matches at large pages and misses at small ones. Commands and fills are also injected in the middle of a walk, and the reference model compares the exist vector every cycle, which exposes both the ordering and the busy lockout.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
  localparam int ASID_W   = 10;
  localparam int PS_W     = 6;
  localparam int PAGE_LSB = 13;

  typedef enum logic [1:0] {
    KIND_BY_OP     = 2'd0,
    KIND_LINE_ALL  = 2'd1,
    KIND_LINE_ASID = 2'd2,
    KIND_RSVD      = 2'd3
  } inv_kind_e;

  localparam logic [2:0] OP_ALL0     = 3'd0;
  localparam logic [2:0] OP_ALL1     = 3'd1;
  localparam logic [2:0] OP_GLB      = 3'd2;
  localparam logic [2:0] OP_NGLB     = 3'd3;
  localparam logic [2:0] OP_ASID     = 3'd4;
  localparam logic [2:0] OP_ASID_VA  = 3'd5;
  localparam logic [2:0] OP_ANY_VA   = 3'd6;
  localparam logic [2:0] OP_BAD      = 3'd7;
endpackage

// File: rtl/tlbinv_match.sv
module tlbinv_match
  import tlbinv_pkg::*;
#(
  parameter int SA_ROWS    = 16,
  parameter int SA_WAYS    = 8,
  parameter int FA_ENTRIES = 8,
  parameter int VA_W       = 32,
  localparam int SA_N      = SA_ROWS * SA_WAYS,
  localparam int N         = SA_N + FA_ENTRIES,
  localparam int PTR_W     = $clog2(N),
  localparam int IDX_W     = PTR_W + 1,
  localparam int VPPN_W    = VA_W - PAGE_LSB
) (
  input  inv_kind_e          kind_i,
  input  logic [2:0]         op_i,
  input  logic [ASID_W-1:0]  asid_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [IDX_W-1:0]   index_i,
  input  logic [PTR_W-1:0]   ent_idx_i,
  input  logic               ent_g_i,
  input  logic [ASID_W-1:0]  ent_asid_i,
  input  logic [PS_W-1:0]    ent_ps_i,
  input  logic [VPPN_W-1:0]  ent_vppn_i,
  output logic               hit_o
);
  localparam int ROW_W = (SA_ROWS > 1) ? $clog2(SA_ROWS) : 1;

  logic [IDX_W-1:0] ent_ext;
  logic [PS_W:0]    shamt;
  logic [VA_W-1:0]  keep_mask;
  logic             asid_eq, addr_eq, row_eq;
  logic             cmd_in_sa, cmd_in_fa, ent_in_sa, line_sel;

  assign ent_ext   = {1'b0, ent_idx_i};
  assign shamt     = {1'b0, ent_ps_i} + 1'b1;
  assign keep_mask = {VA_W{1'b1}} << shamt;
  assign asid_eq   = (ent_asid_i == asid_i);
  assign addr_eq   = ((vaddr_i ^ {ent_vppn_i, {PAGE_LSB{1'b0}}}) & keep_mask) == '0;

  // Row comparison: bit slice when the row count is a power of two.
  generate
    if ((SA_ROWS > 1) && ((SA_ROWS & (SA_ROWS - 1)) == 0)) begin : g_row_pow2
      assign row_eq = (ent_ext[ROW_W-1:0] == index_i[ROW_W-1:0]);
    end else begin : g_row_mod
      assign row_eq = ((ent_ext % IDX_W'(SA_ROWS)) == (index_i % IDX_W'(SA_ROWS)));
    end
  endgenerate

  assign cmd_in_sa = (index_i < IDX_W'(SA_N));
  assign cmd_in_fa = !cmd_in_sa && (index_i < IDX_W'(N));
  assign ent_in_sa = (ent_ext < IDX_W'(SA_N));
  assign line_sel  = (cmd_in_sa && ent_in_sa && row_eq) || (cmd_in_fa && !ent_in_sa);

  always_comb begin
    hit_o = 1'b0;
    unique case (kind_i)
      KIND_BY_OP: begin
        unique case (op_i)
          OP_ALL0, OP_ALL1: hit_o = 1'b1;
          OP_GLB:           hit_o = ent_g_i;
          OP_NGLB:          hit_o = !ent_g_i;
          OP_ASID:          hit_o = !ent_g_i && asid_eq;
          OP_ASID_VA:       hit_o = !ent_g_i && asid_eq && addr_eq;
          OP_ANY_VA:        hit_o = (ent_g_i || asid_eq) && addr_eq;
          default:          hit_o = 1'b0;
        endcase
      end
      KIND_LINE_ALL:  hit_o = line_sel;
      KIND_LINE_ASID: hit_o = line_sel && !ent_g_i && asid_eq;
      default:        hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlbinv_store.sv
module tlbinv_store
  import tlbinv_pkg::*;
#(
  parameter int N      = 136,
  parameter int VA_W   = 32,
  localparam int PTR_W  = $clog2(N),
  localparam int VPPN_W = VA_W - PAGE_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [PTR_W-1:0]   wr_idx_i,
  input  logic               wr_g_i,
  input  logic [ASID_W-1:0]  wr_asid_i,
  input  logic [PS_W-1:0]    wr_ps_i,
  input  logic [VPPN_W-1:0]  wr_vppn_i,
  input  logic               clr_en_i,
  input  logic [PTR_W-1:0]   clr_idx_i,
  input  logic [PTR_W-1:0]   rd_idx_i,
  output logic               rd_g_o,
  output logic [ASID_W-1:0]  rd_asid_o,
  output logic [PS_W-1:0]    rd_ps_o,
  output logic [VPPN_W-1:0]  rd_vppn_o,
  output logic [N-1:0]       exist_o
);
  logic [N-1:0]             ent_g_q;
  logic [N-1:0][ASID_W-1:0] ent_asid_q;
  logic [N-1:0][PS_W-1:0]   ent_ps_q;
  logic [N-1:0][VPPN_W-1:0] ent_vppn_q;
  logic [N-1:0]             exist_q, exist_d, wr_sel;

  generate
    for (genvar e = 0; e < N; e++) begin : g_ent
      assign wr_sel[e]  = wr_en_i && (wr_idx_i == PTR_W'(e));
      assign exist_d[e] = wr_sel[e] ? 1'b1 :
                          (clr_en_i && (clr_idx_i == PTR_W'(e))) ? 1'b0 : exist_q[e];
    end
  endgenerate

  always_ff @(posedge clk) begin
    for (int e = 0; e < N; e++) begin
      if (wr_sel[e]) begin
        ent_g_q[e]    <= wr_g_i;
        ent_asid_q[e] <= wr_asid_i;
        ent_ps_q[e]   <= wr_ps_i;
        ent_vppn_q[e] <= wr_vppn_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exist_q <= '0;
    else        exist_q <= exist_d;
  end

  assign rd_g_o    = ent_g_q[rd_idx_i];
  assign rd_asid_o = ent_asid_q[rd_idx_i];
  assign rd_ps_o   = ent_ps_q[rd_idx_i];
  assign rd_vppn_o = ent_vppn_q[rd_idx_i];
  assign exist_o   = exist_q;

  // R2: an exist bit may only rise after a fill request
  p_rise_only_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i) |-> ((exist_q & ~$past(exist_q)) == '0));
  // R12: at most one exist bit cleared per cycle
  p_one_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(exist_q) & ~exist_q) <= 1);
  // R12: clearing only happens on a walker request
  p_clear_only_walk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_en_i) |-> (($past(exist_q) & ~exist_q) == '0));
endmodule

// File: rtl/tlbinv_walk.sv
module tlbinv_walk
  import tlbinv_pkg::*;
#(
  parameter int N      = 136,
  parameter int VA_W   = 32,
  localparam int PTR_W = $clog2(N),
  localparam int IDX_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid_i,
  input  inv_kind_e          cmd_kind_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [ASID_W-1:0]  cmd_asid_i,
  input  logic [VA_W-1:0]    cmd_vaddr_i,
  input  logic [IDX_W-1:0]   cmd_index_i,
  input  logic               hit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic [PTR_W-1:0]   ptr_o,
  output logic               clr_en_o,
  output inv_kind_e          l_kind_o,
  output logic [2:0]         l_op_o,
  output logic [ASID_W-1:0]  l_asid_o,
  output logic [VA_W-1:0]    l_vaddr_o,
  output logic [IDX_W-1:0]   l_index_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N - 1);

  logic             busy_q, busy_d, done_q, done_d, ill_q, ill_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             legal, load;

  assign legal = (cmd_kind_i == KIND_BY_OP) ? (cmd_op_i != OP_BAD)
                                            : (cmd_kind_i != KIND_RSVD);
  assign load  = cmd_valid_i && !busy_q && legal;

  always_comb begin
    busy_d   = busy_q;
    ptr_d    = ptr_q;
    done_d   = 1'b0;
    ill_d    = 1'b0;
    clr_en_o = 1'b0;
    if (busy_q) begin
      clr_en_o = hit_i;
      if (ptr_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (cmd_valid_i) begin
      if (legal) begin
        busy_d = 1'b1;
        ptr_d  = '0;
      end else begin
        ill_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      ill_q  <= ill_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      l_kind_o  <= cmd_kind_i;
      l_op_o    <= cmd_op_i;
      l_asid_o  <= cmd_asid_i;
      l_vaddr_o <= cmd_vaddr_i;
      l_index_o <= cmd_index_i;
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign ptr_o     = ptr_q;

  // R3: done follows the end of a walk, never during it
  p_done_after_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  // R12: the walk pointer advances by one each busy cycle
  p_ptr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (ptr_q == $past(ptr_q) + 1'b1));
  // R8: an illegal pulse follows an idle request and starts no walk
  p_illegal_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |-> (!busy_q && $past(cmd_valid_i) && !$past(busy_q)));
  // R3: a walk starts at entry zero
  p_start_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (ptr_q == '0));
endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq
  import tlbinv_pkg::*;
#(
  parameter int SA_ROWS    = 16,
  parameter int SA_WAYS    = 8,
  parameter int FA_ENTRIES = 8,
  parameter int VA_W       = 32,
  localparam int SA_N      = SA_ROWS * SA_WAYS,
  localparam int N         = SA_N + FA_ENTRIES,
  localparam int PTR_W     = $clog2(N),
  localparam int IDX_W     = PTR_W + 1,
  localparam int VPPN_W    = VA_W - PAGE_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_kind,
  input  logic [2:0]         cmd_op,
  input  logic [9:0]         cmd_asid,
  input  logic [VA_W-1:0]    cmd_vaddr,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic               fill_en,
  input  logic [PTR_W-1:0]   fill_index,
  input  logic               fill_global,
  input  logic [9:0]         fill_asid,
  input  logic [5:0]         fill_ps,
  input  logic [VPPN_W-1:0]  fill_vppn,
  output logic               busy_o,
  output logic               done_o,
  output logic               illegal_o,
  output logic [N-1:0]       exist_o
);
  logic               fill_ok, hit, clr_en;
  logic [PTR_W-1:0]   ptr;
  inv_kind_e          l_kind;
  logic [2:0]         l_op;
  logic [ASID_W-1:0]  l_asid;
  logic [VA_W-1:0]    l_vaddr;
  logic [IDX_W-1:0]   l_index;
  logic               rd_g;
  logic [ASID_W-1:0]  rd_asid;
  logic [PS_W-1:0]    rd_ps;
  logic [VPPN_W-1:0]  rd_vppn;

  assign fill_ok = fill_en && !busy_o;

  tlbinv_walk #(.N(N), .VA_W(VA_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_kind_i(inv_kind_e'(cmd_kind)),
    .cmd_op_i(cmd_op), .cmd_asid_i(cmd_asid), .cmd_vaddr_i(cmd_vaddr),
    .cmd_index_i(cmd_index), .hit_i(hit),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o),
    .ptr_o(ptr), .clr_en_o(clr_en),
    .l_kind_o(l_kind), .l_op_o(l_op), .l_asid_o(l_asid),
    .l_vaddr_o(l_vaddr), .l_index_o(l_index)
  );

  tlbinv_store #(.N(N), .VA_W(VA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(fill_ok), .wr_idx_i(fill_index), .wr_g_i(fill_global),
    .wr_asid_i(fill_asid), .wr_ps_i(fill_ps), .wr_vppn_i(fill_vppn),
    .clr_en_i(clr_en), .clr_idx_i(ptr), .rd_idx_i(ptr),
    .rd_g_o(rd_g), .rd_asid_o(rd_asid), .rd_ps_o(rd_ps), .rd_vppn_o(rd_vppn),
    .exist_o(exist_o)
  );

  tlbinv_match #(.SA_ROWS(SA_ROWS), .SA_WAYS(SA_WAYS), .FA_ENTRIES(FA_ENTRIES),
                 .VA_W(VA_W)) u_match (
    .kind_i(l_kind), .op_i(l_op), .asid_i(l_asid), .vaddr_i(l_vaddr),
    .index_i(l_index), .ent_idx_i(ptr), .ent_g_i(rd_g), .ent_asid_i(rd_asid),
    .ent_ps_i(rd_ps), .ent_vppn_i(rd_vppn), .hit_o(hit)
  );

  // R3: busy and done never overlap, and illegal never comes with busy
  p_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o) && !(illegal_o && busy_o));
  // R2: a fill offered while busy leaves the exist vector untouched by fills
  p_fill_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_o) |-> ((exist_o & ~$past(exist_o)) == '0));
endmodule

// File: tb/tlbinv_seq_tb_top.sv
module tlbinv_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16, WAYS = 8, FA = 8, VA_W = 32;
  localparam int SA_N = ROWS * WAYS;
  localparam int N = SA_N + FA;
  localparam int PTR_W = $clog2(N);
  localparam int IDX_W = PTR_W + 1;
  localparam int VPPN_W = VA_W - 13;
  localparam longint VX = 64'h0012_3456;

  logic clk = 1'b0, rst_n = 1'b1;
  logic cmd_valid = 1'b0, fill_en = 1'b0, fill_global = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [2:0] cmd_op = '0;
  logic [9:0] cmd_asid = '0, fill_asid = '0;
  logic [VA_W-1:0] cmd_vaddr = '0;
  logic [IDX_W-1:0] cmd_index = '0;
  logic [PTR_W-1:0] fill_index = '0;
  logic [5:0] fill_ps = '0;
  logic [VPPN_W-1:0] fill_vppn = '0;
  logic busy_o, done_o, illegal_o;
  logic [N-1:0] exist_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbinv_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_op(cmd_op), .cmd_asid(cmd_asid), .cmd_vaddr(cmd_vaddr),
    .cmd_index(cmd_index), .fill_en(fill_en), .fill_index(fill_index),
    .fill_global(fill_global), .fill_asid(fill_asid), .fill_ps(fill_ps),
    .fill_vppn(fill_vppn), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .exist_o(exist_o)
  );

  // ---------------- reference model ----------------
  bit m_ex[N], m_g[N];
  int m_asid[N], m_ps[N];
  longint m_vppn[N];
  bit m_busy, m_done, m_ill;
  int m_pos, l_kind, l_op, l_asid, l_idx;
  longint l_va;

  function automatic bit ref_hit(int e);
    bit am, aeq, sel;
    int sh;
    sh  = m_ps[e] + 1;
    am  = ((l_va >> sh) == (m_vppn[e] >> (sh - 13)));
    aeq = (m_asid[e] == l_asid);
    if (l_idx < SA_N)  sel = (e < SA_N) && ((e % ROWS) == (l_idx % ROWS));
    else if (l_idx < N) sel = (e >= SA_N);
    else sel = 1'b0;
    if (l_kind == 0) begin
      case (l_op)
        0, 1: return 1'b1;
        2: return m_g[e];
        3: return !m_g[e];
        4: return !m_g[e] && aeq;
        5: return !m_g[e] && aeq && am;
        6: return (m_g[e] || aeq) && am;
        default: return 1'b0;
      endcase
    end
    if (l_kind == 1) return sel;
    if (l_kind == 2) return sel && !m_g[e] && aeq;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) m_ex[e] = 1'b0;
      m_busy = 0; m_done = 0; m_ill = 0; m_pos = 0;
    end else begin
      bit nd, ni;
      nd = 0; ni = 0;
      if (m_busy) begin
        if (ref_hit(m_pos)) m_ex[m_pos] = 1'b0;
        if (m_pos == N - 1) begin m_busy = 0; nd = 1; end
        else m_pos++;
      end else begin
        if (fill_en && int'(fill_index) < N) begin
          m_ex[fill_index] = 1'b1; m_g[fill_index] = fill_global;
          m_asid[fill_index] = fill_asid; m_ps[fill_index] = fill_ps;
          m_vppn[fill_index] = longint'(fill_vppn);
        end
        if (cmd_valid) begin
          if ((cmd_kind == 0 && cmd_op == 7) || cmd_kind == 3) ni = 1;
          else begin
            m_busy = 1; m_pos = 0;
            l_kind = cmd_kind; l_op = cmd_op; l_asid = cmd_asid;
            l_va = longint'(cmd_vaddr); l_idx = cmd_index;
          end
        end
      end
      m_done = nd; m_ill = ni;
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_on = 0, finished = 0;
  string cur_req = "R1";

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int e = 0; e < N; e++) v[e] = m_ex[e];
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !finished) begin
      chk(exist_o == model_vec(), cur_req, "exist per cycle", exist_o, model_vec());
      chk({busy_o, done_o, illegal_o} == {m_busy, m_done, m_ill}, cur_req,
          "busy/done/illegal per cycle", N'({busy_o, done_o, illegal_o}),
          N'({m_busy, m_done, m_ill}));
    end
  end

  task automatic report();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      report();
    end
  end

  // ---------------- stimulus ----------------
  function automatic bit pat_g(int e, int s); return ((e + s) % 4) == 1; endfunction

  task automatic fill_all(int s);
    for (int e = 0; e < N; e++) begin
      @(negedge clk);
      fill_en = 1; fill_index = PTR_W'(e); fill_global = pat_g(e, s);
      fill_asid = 10'((e / 2 + s) % 3); fill_ps = 6'(12 + ((e + s) % 5));
      fill_vppn = (e % 2 == 0) ? VPPN_W'((VX >> 13) ^ (e % 8)) : VPPN_W'(e * 37 + s);
    end
    @(negedge clk); fill_en = 0;
  endtask

  task automatic issue(int kind, int op, int asid, longint va, int idx, string req);
    cur_req = req;
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 2'(kind); cmd_op = 3'(op); cmd_asid = 10'(asid);
    cmd_vaddr = VA_W'(va); cmd_index = IDX_W'(idx);
    @(negedge clk); cmd_valid = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] snap, gmask;
    #2 rst_n = 0;
    chk_on = 1;
    repeat (3) @(negedge clk);
    chk({exist_o, busy_o, done_o, illegal_o} == '0, "R1", "reset state",
        exist_o, '0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(exist_o == '0 && !busy_o, "R1", "after release", exist_o, '0);

    cur_req = "R2"; fill_all(0);
    chk(exist_o == {N{1'b1}}, "R2", "all filled", exist_o, {N{1'b1}});
    for (int e = 0; e < N; e++) gmask[e] = pat_g(e, 0);
    issue(0, 2, 0, 0, 0, "R4");
    chk(exist_o == ~gmask, "R4", "op2 leaves non-global", exist_o, ~gmask);
    issue(0, 3, 0, 0, 0, "R4");
    chk(exist_o == '0, "R4", "op3 after op2 empties", exist_o, '0);

    cur_req = "R2"; fill_all(1);
    issue(0, 4, 1, 0, 0, "R5");
    issue(0, 5, 2, VX, 0, "R6");
    issue(0, 6, 0, VX, 0, "R7");
    issue(0, 0, 0, 0, 0, "R4");
    chk(exist_o == '0, "R4", "op0 clears all", exist_o, '0);

    cur_req = "R2"; fill_all(2);
    issue(0, 5, 1, VX ^ 64'h8000, 0, "R7");
    issue(0, 6, 2, VX, 0, "R6");
    issue(0, 1, 0, 0, 0, "R4");
    chk(exist_o == '0, "R4", "op1 clears all", exist_o, '0);

    cur_req = "R2"; fill_all(3);
    snap = exist_o;
    issue(0, 7, 0, 0, 0, "R8");
    chk(exist_o == snap, "R8", "opcode 7 changes nothing", exist_o, snap);
    issue(3, 0, 0, 0, 0, "R8");
    chk(exist_o == snap, "R8", "reserved kind changes nothing", exist_o, snap);
    issue(1, 0, 0, 0, 5, "R9");
    issue(1, 0, 0, 0, ROWS + 9, "R9");
    issue(2, 0, 1, 0, SA_N + 3, "R11");
    issue(2, 0, 0, 0, 2 * ROWS + 2, "R11");
    snap = exist_o;
    issue(1, 0, 0, 0, N + 7, "R10");
    chk(exist_o == snap, "R10", "index beyond range", exist_o, snap);
    issue(1, 0, 0, 0, SA_N + 1, "R10");

    // Commands and fills offered mid-walk must be ignored.
    cur_req = "R2"; fill_all(0);
    cur_req = "R3";
    @(negedge clk);
    cmd_valid = 1; cmd_kind = 0; cmd_op = 3'd4; cmd_asid = 10'd2;
    @(negedge clk); cmd_valid = 0;
    repeat (20) @(negedge clk);
    cmd_valid = 1; cmd_kind = 0; cmd_op = 3'd0;
    fill_en = 1; fill_index = PTR_W'(N - 1); fill_global = 0; fill_asid = 10'd2;
    @(negedge clk); cmd_valid = 0; fill_en = 0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(exist_o != '0, "R3", "busy lockout kept entries", exist_o, model_vec());
    issue(0, 3, 0, 0, 0, "R12");
    chk(exist_o == gmask, "R12", "walk ordering leaves globals", exist_o, gmask);

    repeat (3) @(negedge clk);
    report();
  end
endmodule